// File: doc/BRIEF.md
# Register-Programmed SPI Master with Word FIFOs

This block is a full-duplex SPI bus master that software drives through a small 32-bit register window. Software fills an eight-entry transmit queue by writing the transmit data register, picks the word length, clock mode, clock rate and target device in the control register, and then writes a one to the exchange bit. The controller sends the queued words back to back on MOSI while it captures MISO. Each completed word goes into an eight-entry receive queue, which software drains by reading the receive data register.

The serial clock runs at the system clock divided by four shifted left by a 3-bit rate code. That gives periods from 4 to 512 system clocks. One of four chip-select lines is asserted for the whole burst, with a programmable active level. A level interrupt reports an empty transmit queue, waiting receive data, or both, and each source has its own enable. A soft-reset register empties both queues and clears the control register.

Top module: `spi_fifo_master`

## Requirements
- R1: After the synchronous reset `rst`, every chip-select line is high, `sclk` and `irq` are 0, the control and interrupt-enable registers read 0, and status reads 0x1 (transmit queue empty).
- R2: The registers sit at these byte offsets: 0x00 receive data, 0x04 transmit data, 0x08 control, 0x0C interrupt enable, 0x14 status, 0x1C soft reset. The control fields are: enable bit 0, master bit 1, exchange bit 2, clock polarity bit 4, clock phase bit 5, chip-select level bit 7 (1 = active high), word length minus one in [12:8], rate code in [18:16] and chip-select index in [25:24]. All of them read back as written, except the exchange bit (see R7).
- R3: Each word sent produces exactly one received word. Bits go out and come in most significant bit first. A word is 1 to 32 bits long, and the received word is right-aligned with zeros above it.
- R4: While no word is shifting, `sclk` rests at the polarity bit. With phase 0, MISO is sampled and the slave samples MOSI on the first edge of each clock period, and MOSI changes on the second edge. With phase 1 the two roles swap.
- R5: The serial clock period is (4 << rate code) system clocks.
- R6: During a burst only the selected chip-select line is at the active level. Between bursts all four lines are at the inactive level.
- R7: Writing 1 to the exchange bit starts a burst, but only while enable and master are set. The bit reads 1 until the transmit queue is empty and the last word has finished shifting, then clears itself. Writing 0 to it has no effect.
- R8: The transmit queue holds 8 words, and a write to a full queue is discarded. Status bit 1 reports a full transmit queue and status bit 0 an empty one.
- R9: A read of receive data returns the oldest received word and removes it. Status bit 3 is 1 while the receive queue is not empty. A read from an empty queue returns 0.
- R10: A word that arrives while the receive queue already holds 8 words is discarded and sets sticky status bit 7. Any write to the status register clears it.
- R11: The interrupt-enable register has transmit-empty at bit 0 and receive-ready at bit 3. `irq` is 1, one clock after the conditions, whenever an enabled source is true.
- R12: Writing a value with bit 0 set to the soft-reset register empties both queues, clears the overflow flag, stops any burst and returns the control register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after `bus_rd` |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_out | output | 4 | Chip-select lines |

## Verification
The assertions assume that software leaves the clock polarity and chip-select level unchanged while a burst is running. Changes while idle are allowed; the checks on idle levels allow one clock for such a change to take effect. The bench follows this rule. It writes the mode fields with the exchange bit clear, then writes them again with the exchange bit set. It never touches the control register again until it reads the exchange bit back as 0. A bus model answers on MISO with MOSI, optionally inverted, so every received word is predictable from the words sent.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = $clog2(DATA_W);
  localparam int RATE_W = 3;
  localparam int CS_N   = 4;
  localparam int CS_W   = $clog2(CS_N);

  // register byte offsets (software-visible)
  localparam logic [7:0] OFS_RXDATA = 8'h00;
  localparam logic [7:0] OFS_TXDATA = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_INTEN  = 8'h0C;
  localparam logic [7:0] OFS_STAT   = 8'h14;
  localparam logic [7:0] OFS_SRST   = 8'h1C;

  // control field positions
  localparam int C_EN     = 0;
  localparam int C_MASTER = 1;
  localparam int C_XCH    = 2;
  localparam int C_CPOL   = 4;
  localparam int C_CPHA   = 5;
  localparam int C_CSPOL  = 7;
  localparam int C_LEN_LO = 8;
  localparam int C_RATE_LO = 16;
  localparam int C_SEL_LO = 24;

  // status and interrupt-enable bits
  localparam int S_TXE = 0;
  localparam int S_TXF = 1;
  localparam int S_RXR = 3;
  localparam int S_OVF = 7;
  localparam int I_TE  = 0;
  localparam int I_RR  = 3;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic              cspol;
    logic [CS_W-1:0]   cs_sel;
    logic [LEN_W-1:0]  len_m1;
    logic [RATE_W-1:0] rate;
  } shift_cfg_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH) + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  // storage carries no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_rate_tick.sv
module spi_rate_tick #(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  localparam int CW = (1 << RW) + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;

  // half period of the serial clock is 2 << rate system clocks
  assign half_m1 = (CW'(2) << rate) - CW'(1);
  assign tick    = run && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst || !run)        cnt <= '0;
    else if (cnt == half_m1) cnt <= '0;
    else                     cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              run,
  input  shift_cfg_t        cfg,
  input  logic              tx_avail,
  input  logic [DATA_W-1:0] tx_word,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_N-1:0]   cs_out
);
  shift_cfg_t        cfg_q;
  logic [LEN_W:0]    edge_cnt;
  logic [DATA_W-1:0] tx_sr, rx_sr, rx_next, aligned;
  logic [CS_N-1:0]   cs_act;
  logic              tick, lead, samp, shft, last, start_idle, start_next;

  spi_rate_tick #(.RW(RATE_W)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .rate (cfg_q.rate),
    .tick (tick)
  );

  assign lead       = ~edge_cnt[0];
  assign samp       = tick && (lead ^ cfg_q.cpha);
  assign shft       = tick && !(lead ^ cfg_q.cpha);
  assign last       = tick && (edge_cnt == {cfg_q.len_m1, 1'b1});
  assign start_idle = !busy && run && tx_avail;
  assign start_next = busy && last && run && tx_avail;
  assign tx_pop     = !rst && !abort && (start_idle || start_next);
  assign rx_next    = {rx_sr[DATA_W-2:0], miso};
  assign aligned    = tx_word << (LEN_W'(DATA_W - 1) - cfg.len_m1);

  generate
    for (genvar i = 0; i < CS_N; i++) begin : g_cs
      assign cs_act[i] = (cfg.cs_sel == CS_W'(i)) ? cfg.cspol : ~cfg.cspol;
    end
  endgenerate

  always_ff @(posedge clk) begin
    rx_push <= 1'b0;
    if (rst) begin
      busy     <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      cs_out   <= '1;
      edge_cnt <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_word  <= '0;
      cfg_q    <= '0;
    end else if (abort) begin
      busy   <= 1'b0;
      sclk   <= cfg.cpol;
      cs_out <= {CS_N{~cfg.cspol}};
    end else begin
      if (!busy) begin
        sclk   <= cfg.cpol;
        cs_out <= {CS_N{~cfg.cspol}};
      end else if (tick) begin
        sclk     <= ~sclk;
        edge_cnt <= edge_cnt + 1'b1;
        if (samp) rx_sr <= rx_next;
        if (shft) begin
          mosi  <= tx_sr[DATA_W-1];
          tx_sr <= tx_sr << 1;
        end
        if (last) begin
          rx_push <= 1'b1;
          rx_word <= cfg_q.cpha ? rx_next : rx_sr;
          if (!start_next) busy <= 1'b0;
        end
      end
      if (tx_pop) begin
        busy     <= 1'b1;
        cfg_q    <= cfg;
        edge_cnt <= '0;
        rx_sr    <= '0;
        cs_out   <= cs_act;
        if (!cfg.cpha) begin
          mosi  <= aligned[DATA_W-1];
          tx_sr <= aligned << 1;
        end else begin
          tx_sr <= aligned;
        end
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_N-1:0]   cs_out
);
  localparam int TXC_W = $clog2(TX_DEPTH) + 1;
  localparam int RXC_W = $clog2(RX_DEPTH) + 1;

  shift_cfg_t        cfg;
  logic              ctl_en, ctl_master, xch, te_en, rr_en, ovf;
  logic              hit_rx, hit_tx, hit_ctrl, hit_int, hit_stat, hit_srst;
  logic              wr_tx, wr_ctrl, wr_int, wr_stat, srst, rd_rx;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [TXC_W-1:0]  tx_count;
  logic [RXC_W-1:0]  rx_count;
  logic [DATA_W-1:0] tx_head, rx_head, eng_rx_word;
  logic              eng_tx_pop, eng_rx_push, eng_busy, run;
  logic [31:0]       ctrl_view, stat_view, int_view;

  assign hit_rx   = (bus_addr == ADDR_W'(OFS_RXDATA));
  assign hit_tx   = (bus_addr == ADDR_W'(OFS_TXDATA));
  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_int  = (bus_addr == ADDR_W'(OFS_INTEN));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_srst = (bus_addr == ADDR_W'(OFS_SRST));

  assign wr_tx   = bus_wr && hit_tx;
  assign wr_ctrl = bus_wr && hit_ctrl;
  assign wr_int  = bus_wr && hit_int;
  assign wr_stat = bus_wr && hit_stat;
  assign srst    = bus_wr && hit_srst && bus_wdata[0];
  assign rd_rx   = bus_rd && hit_rx && !rx_empty;
  assign run     = xch && ctl_en && ctl_master;

  spi_word_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) tx_q_i (
    .clk   (clk),
    .rst   (rst),
    .flush (srst),
    .push  (wr_tx),
    .din   (bus_wdata[DATA_W-1:0]),
    .pop   (eng_tx_pop),
    .dout  (tx_head),
    .empty (tx_empty),
    .full  (tx_full),
    .count (tx_count)
  );

  spi_word_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) rx_q_i (
    .clk   (clk),
    .rst   (rst),
    .flush (srst),
    .push  (eng_rx_push),
    .din   (eng_rx_word),
    .pop   (rd_rx),
    .dout  (rx_head),
    .empty (rx_empty),
    .full  (rx_full),
    .count (rx_count)
  );

  spi_shift_engine eng_i (
    .clk      (clk),
    .rst      (rst),
    .abort    (srst),
    .run      (run),
    .cfg      (cfg),
    .tx_avail (!tx_empty),
    .tx_word  (tx_head),
    .tx_pop   (eng_tx_pop),
    .rx_push  (eng_rx_push),
    .rx_word  (eng_rx_word),
    .busy     (eng_busy),
    .sclk     (sclk),
    .mosi     (mosi),
    .miso     (miso),
    .cs_out   (cs_out)
  );

  // control register and exchange flag
  always_ff @(posedge clk) begin
    if (rst || srst) begin
      cfg        <= '0;
      ctl_en     <= 1'b0;
      ctl_master <= 1'b0;
      xch        <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctl_en     <= bus_wdata[C_EN];
        ctl_master <= bus_wdata[C_MASTER];
        cfg.cpol   <= bus_wdata[C_CPOL];
        cfg.cpha   <= bus_wdata[C_CPHA];
        cfg.cspol  <= bus_wdata[C_CSPOL];
        cfg.len_m1 <= bus_wdata[C_LEN_LO +: LEN_W];
        cfg.rate   <= bus_wdata[C_RATE_LO +: RATE_W];
        cfg.cs_sel <= bus_wdata[C_SEL_LO +: CS_W];
      end
      if (wr_ctrl && bus_wdata[C_XCH]) xch <= 1'b1;
      else if (xch && !eng_busy && tx_empty) xch <= 1'b0;
    end
  end

  // interrupt enables, overflow flag, interrupt line
  always_ff @(posedge clk) begin
    if (rst) begin
      te_en <= 1'b0;
      rr_en <= 1'b0;
      ovf   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (wr_int) begin
        te_en <= bus_wdata[I_TE];
        rr_en <= bus_wdata[I_RR];
      end
      if (srst)                         ovf <= 1'b0;
      else if (eng_rx_push && rx_full)  ovf <= 1'b1;
      else if (wr_stat)                 ovf <= 1'b0;
      irq <= (te_en && tx_empty) || (rr_en && !rx_empty);
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[C_EN]                 = ctl_en;
    ctrl_view[C_MASTER]             = ctl_master;
    ctrl_view[C_XCH]                = xch;
    ctrl_view[C_CPOL]               = cfg.cpol;
    ctrl_view[C_CPHA]               = cfg.cpha;
    ctrl_view[C_CSPOL]              = cfg.cspol;
    ctrl_view[C_LEN_LO +: LEN_W]    = cfg.len_m1;
    ctrl_view[C_RATE_LO +: RATE_W]  = cfg.rate;
    ctrl_view[C_SEL_LO +: CS_W]     = cfg.cs_sel;
    stat_view = '0;
    stat_view[S_TXE] = tx_empty;
    stat_view[S_TXF] = tx_full;
    stat_view[S_RXR] = !rx_empty;
    stat_view[S_OVF] = ovf;
    int_view = '0;
    int_view[I_TE] = te_en;
    int_view[I_RR] = rr_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (hit_rx)        bus_rdata <= rx_empty ? '0 : 32'(rx_head);
      else if (hit_ctrl) bus_rdata <= ctrl_view;
      else if (hit_int)  bus_rdata <= int_view;
      else if (hit_stat) bus_rdata <= stat_view;
      else               bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int CS_N     = 4,
  parameter int TX_DEPTH = 8,
  parameter int TXC_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             sclk,
  input logic             cpol,
  input logic             cspol,
  input logic [CS_N-1:0]  cs_out,
  input logic [TXC_W-1:0] tx_count,
  input logic             tx_empty,
  input logic             rx_push,
  input logic             rx_full,
  input logic             ovf,
  input logic             wr_stat,
  input logic             srst,
  input logic             xch
);
  // R6: at most one line at the active level
  p_cs_single_r6: assert property (@(posedge clk) disable iff (rst)
    $stable(cspol) |-> ($countones(cs_out ^ {CS_N{~cspol}}) <= 1));

  // R6: all lines inactive between bursts
  p_cs_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cspol)) |-> (cs_out == {CS_N{~cspol}}));

  // R4: serial clock rests at the polarity bit
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));

  // R8: queue never exceeds its depth
  p_tx_bound_r8: assert property (@(posedge clk) disable iff (rst)
    tx_count <= TXC_W'(TX_DEPTH));

  // R10: a word arriving at a full receive queue raises the flag
  p_ovf_set_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full && !srst) |=> ovf);

  // R10: the flag is sticky until a status write or soft reset
  p_ovf_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf && !wr_stat && !srst) |=> ovf);

  // R7: the exchange bit clears only with an idle engine and empty queue
  p_xch_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(xch) |-> (tx_empty && !busy));

  // R7: shifting only begins after an exchange request
  p_busy_needs_xch_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(xch));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(
  .CS_N     (spi_fifo_pkg::CS_N),
  .TX_DEPTH (TX_DEPTH),
  .TXC_W    (TXC_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .busy     (eng_busy),
  .sclk     (sclk),
  .cpol     (cfg.cpol),
  .cspol    (cfg.cspol),
  .cs_out   (cs_out),
  .tx_count (tx_count),
  .tx_empty (tx_empty),
  .rx_push  (eng_rx_push),
  .rx_full  (rx_full),
  .ovf      (ovf),
  .wr_stat  (wr_stat),
  .srst     (srst),
  .xch      (xch)
);

// File: tb/spi_fifo_master_tb_top.sv
module spi_fifo_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_RX = 5'h00, A_TX = 5'h04, A_CTRL = 5'h08,
                         A_INT = 5'h0C, A_STAT = 5'h14, A_SRST = 5'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, sclk, mosi, miso;
  logic [3:0]  cs_out;
  logic        miso_inv = 1'b1;

  int n_checks = 0, n_fail = 0, cyc = 0;

  // slave model: answers with MOSI, optionally inverted
  assign miso = mosi ^ miso_inv;

  spi_fifo_master dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_out(cs_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor state
  bit          m_cpol = 0, m_cpha = 0, m_cspol = 0;
  int          m_len = 8;
  logic [31:0] cap_words [16];
  logic [31:0] cap_sr = '0;
  int          cap_n = 0, cap_bits = 0;
  logic [3:0]  cs_seen = '0;
  int          last_lead = 0, lead_period = 0;
  bit          seen_lead = 0;

  always @(sclk) begin : mon
    bit lead;
    if (!rst && (cs_out != {4{~m_cspol}})) begin
      lead = (sclk != m_cpol);
      if (lead) begin
        if (seen_lead) lead_period = cyc - last_lead;
        last_lead = cyc;
        seen_lead = 1;
      end
      if (lead ^ m_cpha) begin
        cap_sr   = {cap_sr[30:0], mosi};
        cap_bits = cap_bits + 1;
        cs_seen  = cs_out;
        if (cap_bits == m_len) begin
          if (cap_n < 16) cap_words[cap_n] = cap_sr;
          cap_n    = cap_n + 1;
          cap_bits = 0;
          cap_sr   = '0;
        end
      end
    end
  end

  function automatic logic [31:0] mask_of(int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  function automatic logic [31:0] mk_ctrl(bit en, bit xch, bit cpol, bit cpha,
                                          bit cspol, int len, int rate, int sel);
    return {6'd0, 2'(sel), 5'd0, 3'(rate), 3'd0, 5'(len - 1),
            cspol, 1'b0, cpha, cpol, 1'b0, xch, 1'b1, en};
  endfunction

  function automatic logic [3:0] cs_pat(int sel, bit cspol);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = (i == sel) ? cspol : ~cspol;
    return p;
  endfunction

  function automatic logic [31:0] word_of(int k, int len);
    logic [31:0] w;
    w = (32'h9E37_79B9 * 32'(k + 3)) ^ 32'(len * 257);
    return w & mask_of(len);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic clear_cap();
    cap_n = 0; cap_bits = 0; cap_sr = '0; seen_lead = 0; lead_period = 0;
  endtask

  task automatic do_burst(input bit cpol, input bit cpha, input bit cspol,
                          input int len, input int rate, input int sel);
    logic [31:0] v;
    bit done = 0;
    m_cpol = cpol; m_cpha = cpha; m_cspol = cspol; m_len = len;
    bus_write(A_CTRL, mk_ctrl(1, 0, cpol, cpha, cspol, len, rate, sel));
    repeat (2) @(negedge clk);
    bus_write(A_CTRL, mk_ctrl(1, 1, cpol, cpha, cspol, len, rate, sel));
    for (int i = 0; i < 20000 && !done; i++) begin
      bus_read(A_CTRL, v);
      if (!v[2]) done = 1;
    end
    check("R7 exchange bit self-clears", 32'(done), 32'd1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    logic [31:0] exp_tx [16];
    int lens [4] = '{1, 7, 16, 32};

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 cs_out", 32'(cs_out), 32'hF);
    check("R1 sclk", 32'(sclk), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    bus_read(A_CTRL, v); check("R1 ctrl", v, 32'd0);
    bus_read(A_INT, v);  check("R1 int enable", v, 32'd0);
    bus_read(A_STAT, v); check("R1 status", v, 32'h1);

    // R2 control field readback (enable clear, no exchange)
    bus_write(A_CTRL, mk_ctrl(0, 0, 1, 1, 1, 13, 5, 2));
    bus_read(A_CTRL, v); check("R2 ctrl readback", v, mk_ctrl(0, 0, 1, 1, 1, 13, 5, 2));

    // R3 R4 R6 sweep over modes, lengths and selects
    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
        for (int li = 0; li < 4; li++) begin
          int  len = lens[li];
          int  sel = (pol * 2 + pha + li) % 4;
          bit  csp = bit'((pha + li) % 2);
          clear_cap();
          for (int k = 0; k < 3; k++) begin
            exp_tx[k] = word_of(k + li * 3 + pol * 7, len);
            bus_write(A_TX, exp_tx[k]);
          end
          do_burst(bit'(pol), bit'(pha), csp, len, 0, sel);
          check("R3 word count", 32'(cap_n), 32'd3);
          for (int k = 0; k < 3; k++) begin
            check("R4 slave-sampled MOSI word", cap_words[k], exp_tx[k]);
            bus_read(A_RX, v);
            check("R3 received word", v, (~exp_tx[k]) & mask_of(len));
          end
          check("R6 selected chip select", 32'(cs_seen), 32'(cs_pat(sel, csp)));
          check("R6 idle chip selects", 32'(cs_out), 32'({4{~csp}}));
          check("R4 idle sclk", 32'(sclk), 32'(pol));
          bus_read(A_STAT, v);
          check("R9 receive queue empty", 32'(v[3]), 32'd0);
        end

    // R3 with non-inverting slave
    miso_inv = 1'b0;
    clear_cap();
    bus_write(A_TX, 32'h0000_A3C5);
    do_burst(0, 0, 0, 16, 0, 0);
    bus_read(A_RX, v); check("R3 loopback word", v, 32'h0000_A3C5);
    miso_inv = 1'b1;

    // R5 clock divider sweep
    for (int r = 0; r < 4; r++) begin
      clear_cap();
      bus_write(A_TX, 32'h5A);
      bus_write(A_TX, 32'hC3);
      do_burst(0, 0, 0, 4, r, 1);
      check("R5 sclk period", 32'(lead_period), 32'(4 << r));
      bus_read(A_RX, v); bus_read(A_RX, v);
    end

    // R9 empty read returns zero
    bus_read(A_RX, v); check("R9 empty read", v, 32'd0);

    // R8 full transmit queue drops the ninth word
    clear_cap();
    for (int k = 0; k < 9; k++) bus_write(A_TX, word_of(k + 40, 8));
    bus_read(A_STAT, v); check("R8 full flag", 32'(v[1]), 32'd1);
    do_burst(0, 1, 0, 8, 0, 3);
    check("R8 words sent", 32'(cap_n), 32'd8);

    // R10 overflow with eight words waiting
    clear_cap();
    bus_write(A_TX, 32'h77);
    do_burst(0, 1, 0, 8, 0, 3);
    bus_read(A_STAT, v); check("R10 overflow flag set", 32'(v[7]), 32'd1);
    for (int k = 0; k < 8; k++) begin
      bus_read(A_RX, v);
      check("R9 oldest word first", v, (~word_of(k + 40, 8)) & 32'hFF);
    end
    bus_read(A_STAT, v); check("R10 dropped word absent", 32'(v[3]), 32'd0);
    check("R10 flag still sticky", 32'(v[7]), 32'd1);
    bus_write(A_STAT, 32'd0);
    bus_read(A_STAT, v); check("R10 flag cleared", 32'(v[7]), 32'd0);

    // R11 interrupts
    bus_write(A_INT, 32'h1);
    @(negedge clk);
    check("R11 tx-empty irq", 32'(irq), 32'd1);
    bus_write(A_INT, 32'h8);
    @(negedge clk);
    check("R11 rx-ready irq idle", 32'(irq), 32'd0);
    bus_read(A_INT, v); check("R11 enable readback", v, 32'h8);
    clear_cap();
    bus_write(A_TX, 32'h3C);
    do_burst(1, 0, 1, 8, 0, 0);
    check("R11 rx-ready irq", 32'(irq), 32'd1);
    bus_read(A_RX, v);
    @(negedge clk);
    check("R11 irq after drain", 32'(irq), 32'd0);
    bus_write(A_INT, 32'h0);

    // R7 no burst without enable, R12 soft reset
    clear_cap();
    bus_write(A_TX, 32'h11);
    do_burst(0, 0, 0, 8, 0, 0);
    bus_write(A_TX, 32'h22);
    bus_write(A_CTRL, mk_ctrl(0, 1, 0, 0, 0, 8, 0, 0));
    repeat (60) @(negedge clk);
    check("R7 no shift while disabled", 32'(cap_n), 32'd1);
    bus_read(A_CTRL, v); check("R7 exchange pending", 32'(v[2]), 32'd1);
    bus_read(A_STAT, v); check("R7 word still queued", v & 32'h9, 32'h8);
    bus_write(A_SRST, 32'h1);
    bus_read(A_CTRL, v); check("R12 ctrl cleared", v, 32'd0);
    bus_read(A_STAT, v); check("R12 queues emptied", v, 32'h1);
    repeat (20) @(negedge clk);
    check("R12 no shift after reset", 32'(cap_n), 32'd1);
    check("R12 chip selects idle", 32'(cs_out), 32'hF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule